// File: doc/BRIEF.md
# Multi-Source Reset and Clock-Loss Controller

This block produces the internal reset scopes of a serializer/deserializer core that runs from a reference clock. It collects every source of reset: a power-on interval, a hardware reset pin, a pair of power-down pins, a software reset strobe from the management register space, a change of the serial mode selection and a boundary-scan test reset. Each source has its own qualification rule, and each maps onto the narrowest reset scope that suits it. Power-down and power-on clear everything. The hardware pin clears all logic, including the management registers. A software reset or a mode change clears the core logic and leaves the management registers alone. The test reset touches only the boundary-scan state machine.

The block also watches the transmit and receive parallel clocks. Each one drives a toggle flop, and a synchronizer carries that toggle into the reference domain. If a clock stops long enough, only the matching FIFO is flushed. The flush holds for a short tail after the clock returns, so the FIFO pointers are released in step with the reference clock. The receive clock is watched only while the receiver is in read mode.

A state machine picks the widest active scope. Its states are `ST_POR_HOLD`, `ST_PWR_DOWN`, `ST_HW_RESET`, `ST_CORE_RESET` and `ST_RUN`.
- `ST_POR_HOLD` is entered on power-on. The machine stays there until the power-on counter completes, then takes the scope pick.
- From every other state the machine moves each cycle to the highest-priority active request. The order is power-down, then hardware pin, then core request.
- When no request is active, the machine goes to `ST_RUN`.

All outputs come from registers clocked by the reference clock.

Top module: `rcg_reset_ctrl`

## Requirements
- R1: After `por_n` rises, `full_rst` and every other reset output stay asserted for POR_CYCLES reference cycles (4,608,000 by default, 150 ms at 30.72 MHz), then all deassert.
- R2: Holding both `tx_pd_n` and `rx_pd_n` low for PD_QUAL cycles asserts `full_rst` and all narrower scopes. One power-down pin low on its own has no effect.
- R3: Holding `hw_rst_n` low for PIN_QUAL (7) consecutive cycles asserts `logic_rst_mgmt` and `logic_rst_core` but not `full_rst`. A low pulse shorter than PIN_QUAL restarts the qualifier and has no effect.
- R4: A one-cycle `sw_rst_wr` with `sw_rst_val` = 0 asserts `logic_rst_core` for CORE_HOLD (31) cycles and leaves `logic_rst_mgmt` low. A write of 1 has no effect.
- R5: Any change of `mode_sel` asserts `logic_rst_core` without `logic_rst_mgmt`. The reset holds until `mode_sel` has been stable for CORE_HOLD cycles.
- R6: When `tx_pclk` shows no edge for CLK_LOSS (7) reference cycles, `tx_fifo_flush` asserts and stays asserted while the clock is missing. `rx_fifo_flush` and the logic resets stay low.
- R7: When `rx_read_mode` = 1 and `rx_pclk` stalls for CLK_LOSS cycles, `rx_fifo_flush` asserts. When `rx_read_mode` = 0, a stalled `rx_pclk` has no effect.
- R8: After a missing clock returns, its flush output stays high for FLUSH_TAIL (2) more cycles before it deasserts.
- R9: `jtag_trst_n` low asserts `tap_rst` only. No logic reset and no FIFO flush follows from it.
- R10: Scopes nest, and the widest active scope wins: `full_rst` implies `logic_rst_mgmt`, which implies `logic_rst_core`, which implies both FIFO flushes. A narrower request arriving during a wider reset does not drop the wider one.
- R11: When no source is active, every reset output is low. Each output deasserts on a reference clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| por_n | input | 1 | Raw power-on reset, active low, asynchronous |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| tx_pd_n | input | 1 | Transmit power-down pin, active low |
| rx_pd_n | input | 1 | Receive power-down pin, active low |
| sw_rst_wr | input | 1 | Write strobe of the software reset bit (reference domain) |
| sw_rst_val | input | 1 | Value written to the software reset bit; 0 requests reset |
| mode_sel | input | MODE_W | Serial mode selection |
| rx_read_mode | input | 1 | Receiver read mode; enables receive clock watching |
| tx_pclk | input | 1 | Transmit parallel clock, monitored |
| rx_pclk | input | 1 | Receive parallel clock, monitored |
| jtag_trst_n | input | 1 | Boundary-scan test reset, active low |
| full_rst | output | 1 | Reset of all state and registers |
| logic_rst_mgmt | output | 1 | Logic reset including management registers |
| logic_rst_core | output | 1 | Logic reset excluding management registers |
| tx_fifo_flush | output | 1 | Transmit FIFO flush and pointer reset |
| rx_fifo_flush | output | 1 | Receive FIFO flush and pointer reset |
| tap_rst | output | 1 | Boundary-scan state machine reset |

## Verification
The bench drives reset-pin pulses just below the qualification threshold. A qualifier that failed to restart its count would let such glitches build up into a reset. It also pulses a single power-down pin on its own, which a design that ORs the pins instead of ANDing them would treat as a full reset. It stalls the receive clock with read mode off, where a watcher without the enable would flush the FIFO anyway. It samples the flush output just after a stopped clock resumes, so a design without the release tail would show the flush already gone. Finally, it issues a software reset during a hardware reset. A design that let the last request win would drop the management reset too early.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    typedef enum logic [2:0] {
        ST_POR_HOLD,
        ST_PWR_DOWN,
        ST_HW_RESET,
        ST_CORE_RESET,
        ST_RUN
    } rcg_state_e;
endpackage

// File: rtl/rcg_sync.sv
module rcg_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/rcg_pin_qual.sv
module rcg_pin_qual #(
    parameter int QUAL = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic qualified
);
    localparam int CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] QUAL_V = CW'(QUAL);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!active)         cnt_q <= '0;
        else if (cnt_q != QUAL_V) cnt_q <= cnt_q + 1'b1;
    end

    assign qualified = (cnt_q == QUAL_V);

    // R3
    qual_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(active));
    // R3
    glitch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !qualified);
endmodule

// File: rtl/rcg_clk_watch.sv
module rcg_clk_watch #(
    parameter int LOSS = 7,
    parameter int TAIL = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic enable,
    output logic flush_req
);
    localparam int IW = $clog2(LOSS + 1);
    localparam int TW = $clog2(TAIL + 1);
    localparam logic [IW-1:0] LOSS_V = IW'(LOSS);
    localparam logic [TW-1:0] TAIL_V = TW'(TAIL);

    logic          tgl_q;
    logic [2:0]    sh_q;
    logic [IW-1:0] idle_q;
    logic [TW-1:0] tail_q;
    logic          seen, missing;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], tgl_q};
    end

    assign seen    = sh_q[2] ^ sh_q[1];
    assign missing = enable && (idle_q == LOSS_V);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                 idle_q <= '0;
        else if (!enable || seen)   idle_q <= '0;
        else if (idle_q != LOSS_V)  idle_q <= idle_q + 1'b1;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)            tail_q <= '0;
        else if (!enable)      tail_q <= '0;
        else if (missing)      tail_q <= TAIL_V;
        else if (tail_q != '0) tail_q <= tail_q - 1'b1;
    end

    assign flush_req = missing || (tail_q != '0);

    // R7
    watch_gated_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !enable |=> !flush_req);
    // R8
    flush_tail_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($fell(missing) && enable) |-> flush_req);
endmodule

// File: rtl/rcg_reset_ctrl.sv
module rcg_reset_ctrl
    import rcg_pkg::*;
#(
    parameter int POR_CYCLES = 4608000,
    parameter int PIN_QUAL   = 7,
    parameter int PD_QUAL    = 31,
    parameter int CORE_HOLD  = 31,
    parameter int CLK_LOSS   = 7,
    parameter int FLUSH_TAIL = 2,
    parameter int MODE_W     = 2
) (
    input  logic              ref_clk,
    input  logic              por_n,
    input  logic              hw_rst_n,
    input  logic              tx_pd_n,
    input  logic              rx_pd_n,
    input  logic              sw_rst_wr,
    input  logic              sw_rst_val,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              rx_read_mode,
    input  logic              tx_pclk,
    input  logic              rx_pclk,
    input  logic              jtag_trst_n,
    output logic              full_rst,
    output logic              logic_rst_mgmt,
    output logic              logic_rst_core,
    output logic              tx_fifo_flush,
    output logic              rx_fifo_flush,
    output logic              tap_rst
);
    localparam int SW = MODE_W + 5;
    localparam int PW = $clog2(POR_CYCLES + 1);
    localparam int HW = $clog2(CORE_HOLD + 1);
    localparam logic [PW-1:0] POR_V  = PW'(POR_CYCLES);
    localparam logic [HW-1:0] HOLD_V = HW'(CORE_HOLD);
    localparam logic [SW-1:0] SYNC_RST = {4'b1111, 1'b0, {MODE_W{1'b0}}};

    logic [SW-1:0]     sync_q;
    logic              hw_n_s, txpd_n_s, rxpd_n_s, trst_n_s, rd_mode_s;
    logic [MODE_W-1:0] mode_s, mode_prev_q;
    logic [PW-1:0]     por_cnt_q;
    logic [HW-1:0]     core_cnt_q;
    logic              por_done, pd_req, hw_req, core_req, mode_chg;
    logic              tx_flush_req, rx_flush_req;
    rcg_state_e        state_q, state_d, scope_pick;

    rcg_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk(ref_clk), .rst_n(por_n),
        .d({hw_rst_n, tx_pd_n, rx_pd_n, jtag_trst_n, rx_read_mode, mode_sel}),
        .q(sync_q)
    );
    assign {hw_n_s, txpd_n_s, rxpd_n_s, trst_n_s, rd_mode_s, mode_s} = sync_q;

    rcg_pin_qual #(.QUAL(PIN_QUAL)) u_hw_qual (
        .clk(ref_clk), .rst_n(por_n), .active(!hw_n_s), .qualified(hw_req));
    rcg_pin_qual #(.QUAL(PD_QUAL)) u_pd_qual (
        .clk(ref_clk), .rst_n(por_n), .active(!txpd_n_s && !rxpd_n_s),
        .qualified(pd_req));

    rcg_clk_watch #(.LOSS(CLK_LOSS), .TAIL(FLUSH_TAIL)) u_tx_watch (
        .ref_clk(ref_clk), .rst_n(por_n), .mon_clk(tx_pclk),
        .enable(1'b1), .flush_req(tx_flush_req));
    rcg_clk_watch #(.LOSS(CLK_LOSS), .TAIL(FLUSH_TAIL)) u_rx_watch (
        .ref_clk(ref_clk), .rst_n(por_n), .mon_clk(rx_pclk),
        .enable(rd_mode_s), .flush_req(rx_flush_req));

    // Power-on hold counter
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n)               por_cnt_q <= '0;
        else if (por_cnt_q != POR_V) por_cnt_q <= por_cnt_q + 1'b1;
    end
    assign por_done = (por_cnt_q == POR_V);

    // Core hold: restarted by a software reset write of 0 or a mode change
    assign mode_chg = (mode_s != mode_prev_q);
    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            mode_prev_q <= '0;
            core_cnt_q  <= HOLD_V;
        end else begin
            mode_prev_q <= mode_s;
            if ((sw_rst_wr && !sw_rst_val) || mode_chg) core_cnt_q <= '0;
            else if (core_cnt_q != HOLD_V)              core_cnt_q <= core_cnt_q + 1'b1;
        end
    end
    assign core_req = (core_cnt_q != HOLD_V);

    // Widest active scope
    always_comb begin
        if (pd_req)        scope_pick = ST_PWR_DOWN;
        else if (hw_req)   scope_pick = ST_HW_RESET;
        else if (core_req) scope_pick = ST_CORE_RESET;
        else               scope_pick = ST_RUN;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR_HOLD:   state_d = por_done ? scope_pick : ST_POR_HOLD;
            ST_PWR_DOWN:   state_d = scope_pick;
            ST_HW_RESET:   state_d = scope_pick;
            ST_CORE_RESET: state_d = scope_pick;
            ST_RUN:        state_d = scope_pick;
            default:       state_d = ST_POR_HOLD;
        endcase
    end

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) state_q <= ST_POR_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge ref_clk or negedge por_n) begin
        if (!por_n) begin
            full_rst       <= 1'b1;
            logic_rst_mgmt <= 1'b1;
            logic_rst_core <= 1'b1;
            tx_fifo_flush  <= 1'b1;
            rx_fifo_flush  <= 1'b1;
            tap_rst        <= 1'b1;
        end else begin
            unique case (state_q)
                ST_POR_HOLD, ST_PWR_DOWN: begin
                    full_rst       <= 1'b1;
                    logic_rst_mgmt <= 1'b1;
                    logic_rst_core <= 1'b1;
                end
                ST_HW_RESET: begin
                    full_rst       <= 1'b0;
                    logic_rst_mgmt <= 1'b1;
                    logic_rst_core <= 1'b1;
                end
                ST_CORE_RESET: begin
                    full_rst       <= 1'b0;
                    logic_rst_mgmt <= 1'b0;
                    logic_rst_core <= 1'b1;
                end
                default: begin
                    full_rst       <= 1'b0;
                    logic_rst_mgmt <= 1'b0;
                    logic_rst_core <= 1'b0;
                end
            endcase
            tx_fifo_flush <= (state_q != ST_RUN) || tx_flush_req;
            rx_fifo_flush <= (state_q != ST_RUN) || rx_flush_req;
            tap_rst       <= (state_q == ST_POR_HOLD) || (state_q == ST_PWR_DOWN)
                             || !trst_n_s;
        end
    end

    // R10
    scope_nest_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        full_rst |-> (logic_rst_mgmt && logic_rst_core && tx_fifo_flush && rx_fifo_flush));
    // R1
    por_hold_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state_q == ST_POR_HOLD) |=> full_rst);
    // R4
    core_keeps_mgmt_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state_q == ST_CORE_RESET) |=> (logic_rst_core && !logic_rst_mgmt));
    // R11
    run_clear_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
        (state_q == ST_RUN) |=> (!full_rst && !logic_rst_mgmt && !logic_rst_core));
endmodule

// File: tb/rcg_reset_ctrl_tb.sv
module rcg_reset_ctrl_tb_top;
    localparam int MW = 2;

    logic clk = 1'b0;
    logic por_n = 1'b0, hw_rst_n = 1'b1, tx_pd_n = 1'b1, rx_pd_n = 1'b1;
    logic sw_rst_wr = 1'b0, sw_rst_val = 1'b1, rx_read_mode = 1'b1;
    logic [MW-1:0] mode_sel = '0;
    logic tx_pclk = 1'b0, rx_pclk = 1'b0, jtag_trst_n = 1'b1;
    logic tx_run = 1'b1, rx_run = 1'b1;
    logic full_rst, logic_rst_mgmt, logic_rst_core, tx_fifo_flush, rx_fifo_flush, tap_rst;
    int   n_run = 0, n_fail = 0;

    always #5 clk = ~clk;
    always begin #4; if (tx_run) tx_pclk = ~tx_pclk; end
    always begin #4; if (rx_run) rx_pclk = ~rx_pclk; end

    rcg_reset_ctrl #(.POR_CYCLES(100), .MODE_W(MW)) dut_i (
        .ref_clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .tx_pd_n(tx_pd_n),
        .rx_pd_n(rx_pd_n), .sw_rst_wr(sw_rst_wr), .sw_rst_val(sw_rst_val),
        .mode_sel(mode_sel), .rx_read_mode(rx_read_mode), .tx_pclk(tx_pclk),
        .rx_pclk(rx_pclk), .jtag_trst_n(jtag_trst_n), .full_rst(full_rst),
        .logic_rst_mgmt(logic_rst_mgmt), .logic_rst_core(logic_rst_core),
        .tx_fifo_flush(tx_fifo_flush), .rx_fifo_flush(rx_fifo_flush), .tap_rst(tap_rst));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic all_clear(input string req);
        chk(req, full_rst | logic_rst_mgmt | logic_rst_core | tx_fifo_flush
                 | rx_fifo_flush | tap_rst, 1'b0);
    endtask

    task automatic t_por;
        cyc(3);
        chk("R1 full_rst in por", full_rst, 1'b1);
        chk("R10 core during por", logic_rst_core, 1'b1);
        por_n = 1'b1;
        cyc(50);
        chk("R1 full_rst held", full_rst, 1'b1);
        cyc(70);
        all_clear("R1 R11 released");
    endtask

    task automatic t_hw;
        logic seen = 1'b0;
        hw_rst_n = 1'b0; cyc(4); hw_rst_n = 1'b1;
        for (int i = 0; i < 15; i++) begin cyc(1); seen |= logic_rst_mgmt; end
        chk("R3 short pulse ignored", seen, 1'b0);
        hw_rst_n = 1'b0; cyc(25);
        chk("R3 mgmt reset", logic_rst_mgmt, 1'b1);
        chk("R3 core reset", logic_rst_core, 1'b1);
        chk("R3 no full", full_rst, 1'b0);
        hw_rst_n = 1'b1; cyc(8);
        all_clear("R11 hw release");
    endtask

    task automatic t_pd;
        logic seen = 1'b0;
        tx_pd_n = 1'b0;
        for (int i = 0; i < 50; i++) begin cyc(1); seen |= full_rst; end
        chk("R2 single pin ignored", seen, 1'b0);
        rx_pd_n = 1'b0; cyc(50);
        chk("R2 full_rst", full_rst, 1'b1);
        chk("R10 mgmt under full", logic_rst_mgmt, 1'b1);
        chk("R10 rx flush under full", rx_fifo_flush, 1'b1);
        tx_pd_n = 1'b1; rx_pd_n = 1'b1; cyc(8);
        all_clear("R2 released");
    endtask

    task automatic t_sw;
        sw_rst_wr = 1'b1; sw_rst_val = 1'b1; cyc(1); sw_rst_wr = 1'b0; cyc(5);
        chk("R4 write 1 ignored", logic_rst_core, 1'b0);
        sw_rst_wr = 1'b1; sw_rst_val = 1'b0; cyc(1); sw_rst_wr = 1'b0; sw_rst_val = 1'b1;
        cyc(4);
        chk("R4 core reset", logic_rst_core, 1'b1);
        chk("R4 mgmt kept", logic_rst_mgmt, 1'b0);
        cyc(20);
        chk("R4 still held", logic_rst_core, 1'b1);
        cyc(25);
        all_clear("R4 released");
    endtask

    task automatic t_mode;
        mode_sel = 2'd2; cyc(8);
        chk("R5 core reset", logic_rst_core, 1'b1);
        chk("R5 mgmt kept", logic_rst_mgmt, 1'b0);
        cyc(50);
        all_clear("R5 released");
    endtask

    task automatic t_tx;
        tx_run = 1'b0; cyc(20);
        chk("R6 tx flush", tx_fifo_flush, 1'b1);
        chk("R6 rx untouched", rx_fifo_flush, 1'b0);
        chk("R6 core untouched", logic_rst_core, 1'b0);
        tx_run = 1'b1; cyc(2);
        chk("R8 tx flush tail", tx_fifo_flush, 1'b1);
        cyc(15);
        all_clear("R8 tx released");
    endtask

    task automatic t_rx;
        logic seen = 1'b0;
        rx_run = 1'b0; cyc(20);
        chk("R7 rx flush", rx_fifo_flush, 1'b1);
        chk("R7 tx untouched", tx_fifo_flush, 1'b0);
        rx_run = 1'b1; cyc(2);
        chk("R8 rx flush tail", rx_fifo_flush, 1'b1);
        cyc(15);
        all_clear("R8 rx released");
        rx_read_mode = 1'b0; cyc(5);
        rx_run = 1'b0;
        for (int i = 0; i < 25; i++) begin cyc(1); seen |= rx_fifo_flush; end
        chk("R7 not in read mode ignored", seen, 1'b0);
        rx_run = 1'b1; cyc(5); rx_read_mode = 1'b1; cyc(10);
        all_clear("R7 restored");
    endtask

    task automatic t_trst;
        jtag_trst_n = 1'b0; cyc(6);
        chk("R9 tap_rst", tap_rst, 1'b1);
        chk("R9 no logic reset", logic_rst_core | logic_rst_mgmt, 1'b0);
        chk("R9 no flush", tx_fifo_flush | rx_fifo_flush, 1'b0);
        jtag_trst_n = 1'b1; cyc(6);
        all_clear("R9 released");
    endtask

    task automatic t_overlap;
        hw_rst_n = 1'b0; cyc(20);
        sw_rst_wr = 1'b1; sw_rst_val = 1'b0; cyc(1); sw_rst_wr = 1'b0; sw_rst_val = 1'b1;
        cyc(5);
        chk("R10 mgmt kept over sw", logic_rst_mgmt, 1'b1);
        hw_rst_n = 1'b1; cyc(8);
        chk("R10 narrower remains", logic_rst_core, 1'b1);
        chk("R10 mgmt dropped", logic_rst_mgmt, 1'b0);
        cyc(40);
        all_clear("R11 overlap released");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_por();
        t_hw();
        t_pd();
        t_sw();
        t_mode();
        t_tx();
        t_rx();
        t_trst();
        t_overlap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule